// File: doc/BRIEF.md
# Key-Protected DAC Output Register Interface

This block is the write-protected register front end of a DAC output path. It holds two live settings that drive the converter side. The first is a one-bit source select: direct DAC code, or the sine synthesizer. The second is a 10-bit signed DAC code. A simple single-cycle bus with address, write strobe, write data and read data reaches both settings. A bus write to either setting is only staged in a shadow register. The live setting changes only when software follows a strict three-write unlock/commit ritual.

The ritual has three writes in a row. First, an opening key value goes to a dedicated key address. Next comes one value write to the target setting. Last, a closing key value goes to a second key address. Anything else returns the sequencer to idle and throws away the staged value. A one-cycle pulse marks each successful commit. Reads are never restricted, and they never disturb the sequence.

Top module: `dac_keyreg_if`

## Requirements
- R1: A synchronous active-high reset clears the live mode bit to 0, the live code to 0x000, the commit pulse to 0 and the read data to 0, and returns the sequencer to idle so that any staged value is lost.
- R2: Three consecutive bus writes commit a value to a live setting. They are 0x0007 to the opening-key offset 0x08, then one value write to the mode offset 0x00 or the code offset 0x04, then 0x00B9 to the closing-key offset 0x0C. The live output takes the staged value at the clock edge that accepts the closing key. A closing key that is not part of such a sequence does nothing.
- R3: The mode setting uses bit 0 of the written word: 1 selects direct DAC output and 0 selects synthesizer output. Bits 15:1 of the written word are ignored.
- R4: The code setting is a 10-bit two's-complement value in bits 9:0. 0x000 is midscale, 0x200 is the most negative output and 0x1FF is the most positive. Written bits 15:10 are ignored, and they read as zero.
- R5: Both key comparisons use the whole 16-bit word. A wrong opening key leaves the sequencer idle. A wrong closing key discards the staged value.
- R6: Any write other than the expected next step returns the sequencer to idle and discards the staged value. This covers a write to another offset (an unmapped one included), a second value write, and a repeated opening key.
- R7: A value write that does not directly follow a correct opening key has no effect on either live setting.
- R8: `commit_pulse` is high for exactly the one cycle that follows the clock edge accepting the closing key of a successful commit. It is low at all other times.
- R9: Reads are registered. The address present at a clock edge selects the word that appears on `bus_rdata` during the following cycle. Mode reads back in bit 0 and code in bits 9:0, with all other bits zero. Key offsets and unmapped offsets read as zero. A cycle without a write never changes the sequencer state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 8 | Byte offset of the access |
| bus_wr | input | 1 | Write strobe, one write per cycle high |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Registered read data |
| dac_direct | output | 1 | Live mode: 1 direct DAC code, 0 synthesizer |
| dac_code | output | 10 | Live signed DAC code |
| commit_pulse | output | 1 | One-cycle pulse after a successful commit |

## Verification
A sequencer that advances on a wrong key, or forgets to discard a staged value, shows up at the ports in the same way. A later stray closing key then moves `dac_direct` or `dac_code` and raises `commit_pulse`, visible one cycle after the clock edge that accepted that key. A staging or target-selection fault shows as the wrong output changing, or as reserved bits appearing, on the cycle after the commit edge. A live-register fault shows on `bus_rdata` one cycle after its offset is presented. Each vector therefore ends by checking the pulse, both outputs and both read-backs before the next sequence begins, so a fault cannot hide behind a later write.

// File: rtl/dkr_pkg.sv
package dkr_pkg;

  typedef enum logic [1:0] {
    SEQ_IDLE  = 2'd0,
    SEQ_ARMED = 2'd1,
    SEQ_HELD  = 2'd2
  } seq_state_e;

  typedef struct packed {
    logic rd_mode;
    logic rd_code;
    logic w_any;
    logic w_value;
    logic w_tgt_mode;
    logic w_open_ok;
    logic w_shut_ok;
  } dec_t;

endpackage

// File: rtl/dkr_decode.sv
module dkr_decode
  import dkr_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int DATA_W    = 16,
  parameter int OFS_MODE  = 'h00,
  parameter int OFS_CODE  = 'h04,
  parameter int OFS_KOPEN = 'h08,
  parameter int OFS_KSHUT = 'h0C,
  parameter int KEY_OPEN  = 'h0007,
  parameter int KEY_SHUT  = 'h00B9
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr,
  input  logic [DATA_W-1:0] wdata,
  output dec_t              dec
);

  logic at_mode, at_code, at_kopen, at_kshut;

  always_comb begin
    at_mode  = (addr == ADDR_W'(OFS_MODE));
    at_code  = (addr == ADDR_W'(OFS_CODE));
    at_kopen = (addr == ADDR_W'(OFS_KOPEN));
    at_kshut = (addr == ADDR_W'(OFS_KSHUT));

    dec.rd_mode    = at_mode;
    dec.rd_code    = at_code;
    dec.w_any      = wr;
    dec.w_value    = wr & (at_mode | at_code);
    dec.w_tgt_mode = at_mode;
    dec.w_open_ok  = wr & at_kopen & (wdata == DATA_W'(KEY_OPEN));
    dec.w_shut_ok  = wr & at_kshut & (wdata == DATA_W'(KEY_SHUT));
  end

endmodule

// File: rtl/dkr_key_seq.sv
module dkr_key_seq
  import dkr_pkg::*;
#(
  parameter int CODE_W = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  dec_t              dec,
  input  logic [CODE_W-1:0] wval,
  output logic              commit,
  output logic              tgt_mode,
  output logic [CODE_W-1:0] shadow
);

  seq_state_e state;

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= SEQ_IDLE;
      tgt_mode <= 1'b0;
      shadow   <= '0;
    end else if (dec.w_any) begin
      case (state)
        SEQ_IDLE: begin
          if (dec.w_open_ok) state <= SEQ_ARMED;
        end
        SEQ_ARMED: begin
          if (dec.w_value) begin
            state    <= SEQ_HELD;
            tgt_mode <= dec.w_tgt_mode;
            shadow   <= wval;
          end else begin
            state <= SEQ_IDLE;
          end
        end
        default: begin
          state    <= SEQ_IDLE;
          tgt_mode <= 1'b0;
          shadow   <= '0;
        end
      endcase
    end
  end

  assign commit = (state == SEQ_HELD) & dec.w_shut_ok;

  // R6: the held state is entered only straight from the armed state
  p_held_entry_r6: assert property (@(posedge clk) disable iff (rst)
    (state == SEQ_HELD && $past(state) != SEQ_HELD) |-> $past(state) == SEQ_ARMED);

  // R9: no write, no state change
  p_idle_bus_stable_r9: assert property (@(posedge clk) disable iff (rst)
    !dec.w_any |=> $stable(state));

endmodule

// File: rtl/dkr_live_regs.sv
module dkr_live_regs
  import dkr_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int CODE_W = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              commit,
  input  logic              tgt_mode,
  input  logic [CODE_W-1:0] shadow,
  input  dec_t              dec,
  output logic              mode_q,
  output logic [CODE_W-1:0] code_q,
  output logic              commit_q,
  output logic [DATA_W-1:0] rdata_q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q   <= 1'b0;
      code_q   <= '0;
      commit_q <= 1'b0;
      rdata_q  <= '0;
    end else begin
      commit_q <= commit;
      if (commit && tgt_mode)  mode_q <= shadow[0];
      if (commit && !tgt_mode) code_q <= shadow;
      if (dec.rd_mode)      rdata_q <= DATA_W'(mode_q);
      else if (dec.rd_code) rdata_q <= DATA_W'(code_q);
      else                  rdata_q <= '0;
    end
  end

  // R7: live settings hold unless a commit is presented
  p_hold_without_commit_r7: assert property (@(posedge clk) disable iff (rst)
    !commit |=> ($stable(code_q) && $stable(mode_q)));

  // R4: reserved read bits stay zero
  p_rdata_reserved_r4: assert property (@(posedge clk) disable iff (rst)
    rdata_q[DATA_W-1:CODE_W] == '0);

endmodule

// File: rtl/dac_keyreg_if.sv
module dac_keyreg_if
  import dkr_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int DATA_W    = 16,
  parameter int CODE_W    = 10,
  parameter int OFS_MODE  = 'h00,
  parameter int OFS_CODE  = 'h04,
  parameter int OFS_KOPEN = 'h08,
  parameter int OFS_KSHUT = 'h0C,
  parameter int KEY_OPEN  = 'h0007,
  parameter int KEY_SHUT  = 'h00B9
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              dac_direct,
  output logic [CODE_W-1:0] dac_code,
  output logic              commit_pulse
);

  dec_t              dec;
  logic              commit;
  logic              tgt_mode;
  logic [CODE_W-1:0] shadow;

  dkr_decode #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W),
    .OFS_MODE(OFS_MODE), .OFS_CODE(OFS_CODE),
    .OFS_KOPEN(OFS_KOPEN), .OFS_KSHUT(OFS_KSHUT),
    .KEY_OPEN(KEY_OPEN), .KEY_SHUT(KEY_SHUT)
  ) u_dec (
    .addr (bus_addr),
    .wr   (bus_wr),
    .wdata(bus_wdata),
    .dec  (dec)
  );

  dkr_key_seq #(.CODE_W(CODE_W)) u_seq (
    .clk     (clk),
    .rst     (rst),
    .dec     (dec),
    .wval    (bus_wdata[CODE_W-1:0]),
    .commit  (commit),
    .tgt_mode(tgt_mode),
    .shadow  (shadow)
  );

  dkr_live_regs #(.DATA_W(DATA_W), .CODE_W(CODE_W)) u_live (
    .clk     (clk),
    .rst     (rst),
    .commit  (commit),
    .tgt_mode(tgt_mode),
    .shadow  (shadow),
    .dec     (dec),
    .mode_q  (dac_direct),
    .code_q  (dac_code),
    .commit_q(commit_pulse),
    .rdata_q (bus_rdata)
  );

  // R2: a commit pulse always follows an accepted closing key
  p_commit_keyshut_r2: assert property (@(posedge clk) disable iff (rst)
    commit_pulse |-> $past(bus_wr && bus_addr == ADDR_W'(OFS_KSHUT)
                           && bus_wdata == DATA_W'(KEY_SHUT)));

  // R8: the pulse lasts one cycle
  p_commit_single_r8: assert property (@(posedge clk) disable iff (rst)
    commit_pulse |=> !commit_pulse);

endmodule

// File: tb/sim_dac_keyreg_if.sv
module sim_dac_keyreg_if;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic        dac_direct;
  logic [9:0]  dac_code;
  logic        commit_pulse;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  dac_keyreg_if u0 (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .dac_direct(dac_direct),
    .dac_code(dac_code), .commit_pulse(commit_pulse)
  );

  localparam logic [7:0] A_MODE = 8'h00, A_CODE = 8'h04, A_KO = 8'h08, A_KS = 8'h0C;
  localparam int NV = 12;
  // {a0,d0,a1,d1,a2,d2,exp_mode,exp_code,exp_commit}
  localparam logic [83:0] VEC [NV] = '{
    {A_KO,16'h0007, A_CODE,16'h01FF, A_KS,16'h00B9, 1'b0,10'h1FF,1'b1}, // R2 R4
    {A_KO,16'h0007, A_MODE,16'h00FF, A_KS,16'h00B9, 1'b1,10'h1FF,1'b1}, // R3
    {A_KO,16'h0007, A_CODE,16'hFE00, A_KS,16'h00B9, 1'b1,10'h200,1'b1}, // R4
    {A_KO,16'h0006, A_CODE,16'h0123, A_KS,16'h00B9, 1'b1,10'h200,1'b0}, // R5
    {A_KO,16'h0007, A_CODE,16'h0055, A_KS,16'h00B8, 1'b1,10'h200,1'b0}, // R5
    {A_KO,16'h0007, A_CODE,16'h0055, A_MODE,16'h0000, 1'b1,10'h200,1'b0}, // R6
    {A_CODE,16'h0077, A_KO,16'h0007, A_KS,16'h00B9, 1'b1,10'h200,1'b0}, // R7
    {A_KO,16'h0007, A_MODE,16'h0000, A_KS,16'h00B9, 1'b0,10'h200,1'b1}, // R3
    {A_KO,16'h0007, A_KO,16'h0007, A_CODE,16'h0111, 1'b0,10'h200,1'b0}, // R6
    {A_KO,16'h0107, A_CODE,16'h0001, A_KS,16'h00B9, 1'b0,10'h200,1'b0}, // R5
    {A_KO,16'h0007, A_CODE,16'h03FF, A_KS,16'h00B9, 1'b0,10'h3FF,1'b1}, // R2
    {A_KO,16'h0007, A_CODE,16'h0155, 8'h10,16'h0000, 1'b0,10'h3FF,1'b0}  // R6
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [15:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [15:0] q);
    @(negedge clk);
    bus_addr = a; bus_wr = 1'b0;
    @(negedge clk);
    q = bus_rdata;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++; failures++;
    $display("FAIL watchdog expired actual=0x1 expected=0x0");
    finish_run();
  end

  initial begin
    logic [15:0] q;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    chk("R1 mode after reset", 32'(dac_direct), 32'h0);
    chk("R1 code after reset", 32'(dac_code), 32'h0);
    chk("R1 pulse after reset", 32'(commit_pulse), 32'h0);
    chk("R1 rdata after reset", 32'(bus_rdata), 32'h0);

    for (int i = 0; i < NV; i++) begin
      wr(VEC[i][83:76], VEC[i][75:60]);
      wr(VEC[i][59:52], VEC[i][51:36]);
      wr(VEC[i][35:28], VEC[i][27:12]);
      chk($sformatf("R8 pulse vec%0d", i), 32'(commit_pulse), 32'(VEC[i][0]));
      chk($sformatf("R2 mode vec%0d", i), 32'(dac_direct), 32'(VEC[i][11]));
      chk($sformatf("R2 code vec%0d", i), 32'(dac_code), 32'(VEC[i][10:1]));
      rd(A_MODE, q);
      chk($sformatf("R9 read mode vec%0d", i), 32'(q), 32'(VEC[i][11]));
      rd(A_CODE, q);
      chk($sformatf("R9 R4 read code vec%0d", i), 32'(q), 32'(VEC[i][10:1]));
    end

    // R6: second value write breaks the sequence
    wr(A_KO, 16'h0007); wr(A_CODE, 16'h00AA); wr(A_CODE, 16'h00BB); wr(A_KS, 16'h00B9);
    chk("R6 double value pulse", 32'(commit_pulse), 32'h0);
    chk("R6 double value code", 32'(dac_code), 32'h3FF);

    // R8: pulse width, then R2: lone closing key after commit
    wr(A_KO, 16'h0007); wr(A_CODE, 16'h0100); wr(A_KS, 16'h00B9);
    chk("R8 pulse high", 32'(commit_pulse), 32'h1);
    chk("R2 code 0x100", 32'(dac_code), 32'h100);
    @(negedge clk);
    chk("R8 pulse low next cycle", 32'(commit_pulse), 32'h0);
    wr(A_KS, 16'h00B9);
    chk("R2 lone closing key pulse", 32'(commit_pulse), 32'h0);
    chk("R2 lone closing key code", 32'(dac_code), 32'h100);

    // R9: key and unmapped offsets read zero
    rd(A_KO, q);   chk("R9 read open key", 32'(q), 32'h0);
    rd(A_KS, q);   chk("R9 read close key", 32'(q), 32'h0);
    rd(8'h20, q);  chk("R9 read unmapped", 32'(q), 32'h0);

    // R1: reset mid-sequence discards staged value
    wr(A_KO, 16'h0007); wr(A_MODE, 16'h0001);
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    chk("R1 code after mid reset", 32'(dac_code), 32'h0);
    wr(A_KS, 16'h00B9);
    chk("R1 no commit after reset", 32'(commit_pulse), 32'h0);
    chk("R1 mode after reset", 32'(dac_direct), 32'h0);

    finish_run();
  end

endmodule